// File: doc/BRIEF.md
# OFDM Symbol Bit Interleaver with Ping-Pong Buffers

This block sits between a convolutional coder and a constellation mapper in an OFDM transmitter. It accepts coded bits as 16-bit words and gathers one symbol's worth of them into a symbol buffer. It then delivers them one subcarrier per cycle, with all the bits that subcarrier's constellation point needs. The bits are reordered by two permutation stages. The first spreads neighbouring coded bits across distant subcarriers. The second makes neighbouring coded bits alternate between the low-order and high-order positions of a constellation point.

A two-bit rate code selects the modulation depth and therefore the symbol size. The block holds two symbol buffers and alternates between them. One symbol can fill while the previous one drains, so even a 288-bit symbol arriving at 16 bits per cycle never stalls a mapper that consumes one subcarrier per cycle.

Subcarriers leave in the order an IFFT with natural bin order expects: the upper half of the data subcarriers first, then the lower half. Both edges use a valid/ready handshake.

Top module: `ofdm_bit_interleaver`

## Requirements
- R1: After synchronous reset, `in_ready` is 1 and `out_valid` is 0.
- R2: The rate code selects bits per subcarrier and bits per symbol: 0 gives 1 and 48, 1 gives 2 and 96, 2 gives 4 and 192, 3 gives 6 and 288. That is 3, 6, 12 or 18 input words. Coded bit k of a symbol is bit `k mod 16` of input word `floor(k/16)`, with bit 0 as the LSB of `in_data`.
- R3: With N bits per symbol and s = max(bpsc/2, 1), coded bit k moves first to i = (N/16)(k mod 16) + floor(k/16), and then to j = s*floor(i/s) + (i + N - floor(16i/N)) mod s. Subcarrier c carries interleaved bits c*bpsc+t on `out_bits[t]` for t < bpsc. The unused upper bits of `out_bits` are 0.
- R4: The n-th subcarrier delivered for a symbol (n = 0..47) is c = (n + 24) mod 48, and `out_sc` shows c.
- R5: No subcarrier of a symbol is offered before its last word is accepted. When the read side is idle, `out_valid` rises one cycle after the clock edge that accepts the last word.
- R6: The rate code is sampled with the first word of a symbol. Changes on `in_rate` during the remaining words of that symbol have no effect. `out_rate` reports the sampled rate.
- R7: A second symbol can be written while the first waits to be read. While both buffers hold undelivered symbols, `in_ready` is 0 and no word is taken.
- R8: Each buffer keeps its own rate. Consecutive symbols of different rates are each read out with their own size and permutation.
- R9: While `out_valid` is 1 and `out_ready` is 0, `out_bits`, `out_sc` and `out_rate` hold their values.
- R10: When the next symbol is already buffered, its first subcarrier follows the previous symbol's last one in the next cycle. Two buffered symbols drain in 96 consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input word valid |
| in_ready | output | 1 | Block can take an input word |
| in_data | input | 16 | Coded bits, LSB is the earliest |
| in_rate | input | 2 | Rate code, sampled on a symbol's first word |
| out_valid | output | 1 | Subcarrier bits valid |
| out_ready | input | 1 | Mapper takes the current subcarrier |
| out_bits | output | 6 | Constellation bits of one subcarrier, unused upper bits 0 |
| out_sc | output | 6 | Data subcarrier index 0..47 |
| out_rate | output | 2 | Rate code of the symbol being read |

## Verification
The hardest state to reach is both buffers full, with the output register stalled partway into the older symbol and a further word waiting at the input. The bench holds `out_ready` low and writes two symbols of different rates. It then keeps a third word offered and confirms the word is refused and the output is frozen. After that it releases the mapper and sends the third symbol, so all three streams are checked bit for bit against a model computed from the permutation formulas. A separate run toggles `out_ready` randomly to stall the stream at arbitrary subcarriers.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int unsigned WORD_BITS = 16;
  localparam int unsigned NUM_SC    = 48;
  localparam int unsigned MAX_BPSC  = 6;

  typedef enum logic [1:0] {
    RATE_BPSK  = 2'd0,
    RATE_QPSK  = 2'd1,
    RATE_QAM16 = 2'd2,
    RATE_QAM64 = 2'd3
  } rate_e;

  // coded bits carried by one subcarrier
  function automatic int unsigned bpsc_of(input rate_e r);
    case (r)
      RATE_BPSK:  return 1;
      RATE_QPSK:  return 2;
      RATE_QAM16: return 4;
      default:    return 6;
    endcase
  endfunction

  // rotation modulus of the second permutation stage
  function automatic int unsigned step_of(input rate_e r);
    case (r)
      RATE_BPSK, RATE_QPSK: return 1;
      RATE_QAM16:           return 2;
      default:              return 3;
    endcase
  endfunction
endpackage

// File: rtl/ilv_perm.sv
// Buffer position of every bit of the word being written (both stages).
module ilv_perm
  import ilv_pkg::*;
#(
  parameter int unsigned WORD_W = WORD_BITS,
  parameter int unsigned NSC    = NUM_SC,
  parameter int unsigned POS_W  = 9,
  parameter int unsigned CNT_W  = 5
) (
  input  rate_e                     rate,
  input  logic [CNT_W-1:0]          wcnt,
  output logic [WORD_W*POS_W-1:0]   pos_flat
);
  // For a word w and bit b: k = WORD_W*w + b, so stage one gives i = nw*b + w
  // and floor(WORD_W*i/N) reduces to b.
  function automatic int unsigned dest(input rate_e r, input int unsigned w,
                                       input int unsigned b);
    int unsigned nw, s, i;
    nw = (NSC * bpsc_of(r)) / WORD_W;
    s  = step_of(r);
    i  = nw * b + w;
    return s * (i / s) + ((i % s) + s - (b % s)) % s;
  endfunction

  for (genvar gb = 0; gb < WORD_W; gb++) begin : g_bit
    localparam int unsigned BI = gb;
    assign pos_flat[gb*POS_W +: POS_W] = POS_W'(dest(rate, 32'(wcnt), BI));
  end
endmodule

// File: rtl/ilv_wr_ctrl.sv
// Write side: word counter, per-symbol rate sampling, buffer selection.
module ilv_wr_ctrl
  import ilv_pkg::*;
#(
  parameter int unsigned NSC    = NUM_SC,
  parameter int unsigned WORD_W = WORD_BITS,
  parameter int unsigned CNT_W  = 5
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             accept,
  input  rate_e            in_rate,
  output logic             wsel,
  output logic [CNT_W-1:0] wcnt,
  output rate_e            cur_rate,
  output logic             sym_done
);
  rate_e            rate_q;
  logic [CNT_W-1:0] last_w;

  assign cur_rate = (wcnt == '0) ? in_rate : rate_q;
  assign last_w   = CNT_W'((NSC * bpsc_of(cur_rate)) / WORD_W - 1);
  assign sym_done = accept && (wcnt == last_w);

  always_ff @(posedge clk) begin
    if (rst) begin
      wsel   <= 1'b0;
      wcnt   <= '0;
      rate_q <= RATE_BPSK;
    end else if (accept) begin
      rate_q <= cur_rate;
      if (sym_done) begin
        wcnt <= '0;
        wsel <= ~wsel;
      end else begin
        wcnt <= wcnt + 1'b1;
      end
    end
  end

  // R2: a partly written symbol never runs past its word count
  a_r2_word_bound: assert property (@(posedge clk) disable iff (rst)
    (wcnt != '0) |-> (32'(wcnt) < (NSC * bpsc_of(rate_q)) / WORD_W));

  // R6: sampled rate does not move while a symbol is being written
  a_r6_rate_held: assert property (@(posedge clk) disable iff (rst)
    (wcnt != '0 && accept) |=> $stable(rate_q));
endmodule

// File: rtl/ilv_rd_ctrl.sv
// Read side: subcarrier counter in IFFT order and registered output stage.
module ilv_rd_ctrl
  import ilv_pkg::*;
#(
  parameter int unsigned NSC   = NUM_SC,
  parameter int unsigned BPSC  = MAX_BPSC,
  parameter int unsigned MAXB  = NSC * BPSC,
  parameter int unsigned POS_W = 9,
  parameter int unsigned SC_W  = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            src_full,
  input  logic [MAXB-1:0] src_bits,
  input  rate_e           src_rate,
  input  logic            out_ready,
  output logic            rsel,
  output logic            rd_done,
  output logic            out_valid,
  output logic [BPSC-1:0] out_bits,
  output logic [SC_W-1:0] out_sc,
  output rate_e           out_rate
);
  localparam int unsigned HALF = NSC / 2;

  logic [SC_W-1:0] rcnt, sc_now;
  logic [BPSC-1:0] bits_now;
  logic            load;

  assign load    = src_full && (!out_valid || out_ready);
  assign rd_done = load && (rcnt == SC_W'(NSC - 1));
  // positive-frequency half first, then the negative half
  assign sc_now  = (rcnt < SC_W'(HALF)) ? rcnt + SC_W'(HALF) : rcnt - SC_W'(HALF);

  always_comb begin
    int unsigned nb, base;
    nb       = bpsc_of(src_rate);
    base     = 32'(sc_now) * nb;
    bits_now = '0;
    for (int t = 0; t < BPSC; t++)
      if (32'(t) < nb) bits_now[t] = src_bits[POS_W'(base + 32'(t))];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_bits  <= '0;
      out_sc    <= '0;
      out_rate  <= RATE_BPSK;
      rcnt      <= '0;
      rsel      <= 1'b0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_bits  <= bits_now;
      out_sc    <= sc_now;
      out_rate  <= src_rate;
      if (rd_done) begin
        rcnt <= '0;
        rsel <= ~rsel;
      end else begin
        rcnt <= rcnt + 1'b1;
      end
    end else if (out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R9: a stalled output is frozen
  a_r9_hold: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_bits) &&
                                   $stable(out_sc) && $stable(out_rate)));

  // R4 / R10: the subcarrier after an accepted one is the next index mod NSC
  a_r4_sc_step: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_ready) |=> (!out_valid ||
      out_sc == (($past(out_sc) == SC_W'(NSC - 1)) ? '0 : $past(out_sc) + 1'b1)));

  // R3: bits above the constellation size are zero
  a_r3_upper_zero: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> ((out_bits >> bpsc_of(out_rate)) == '0));

  a_r4_sc_range: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (32'(out_sc) < NSC));
endmodule

// File: rtl/ofdm_bit_interleaver.sv
module ofdm_bit_interleaver
  import ilv_pkg::*;
#(
  parameter  int unsigned WORD_W = WORD_BITS,
  parameter  int unsigned NSC    = NUM_SC,
  parameter  int unsigned BPSC   = MAX_BPSC,
  localparam int unsigned SC_W   = $clog2(NSC)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [WORD_W-1:0] in_data,
  input  logic [1:0]        in_rate,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BPSC-1:0]   out_bits,
  output logic [SC_W-1:0]   out_sc,
  output logic [1:0]        out_rate
);
  localparam int unsigned MAXB  = NSC * BPSC;
  localparam int unsigned POS_W = $clog2(MAXB);
  localparam int unsigned CNT_W = $clog2(MAXB / WORD_W);

  logic [MAXB-1:0]         sym_buf [2];
  logic [1:0]              full_q;
  rate_e                   tag_q [2];
  logic                    wsel, rsel, accept, sym_done, rd_done;
  logic [CNT_W-1:0]        wcnt;
  rate_e                   cur_rate, rd_rate;
  logic [WORD_W*POS_W-1:0] pos_flat;

  assign in_ready = !full_q[wsel];
  assign accept   = in_valid && in_ready;
  assign out_rate = rd_rate;

  ilv_wr_ctrl #(.NSC(NSC), .WORD_W(WORD_W), .CNT_W(CNT_W)) u_wr (
    .clk(clk), .rst(rst), .accept(accept), .in_rate(rate_e'(in_rate)),
    .wsel(wsel), .wcnt(wcnt), .cur_rate(cur_rate), .sym_done(sym_done)
  );

  ilv_perm #(.WORD_W(WORD_W), .NSC(NSC), .POS_W(POS_W), .CNT_W(CNT_W)) u_perm (
    .rate(cur_rate), .wcnt(wcnt), .pos_flat(pos_flat)
  );

  // symbol storage: scattered write, no reset
  always_ff @(posedge clk) begin
    if (accept)
      for (int b = 0; b < WORD_W; b++)
        sym_buf[wsel][pos_flat[b*POS_W +: POS_W]] <= in_data[b];
  end

  // ownership flags and per-buffer rate tags
  always_ff @(posedge clk) begin
    if (rst) begin
      full_q <= '0;
      tag_q  <= '{RATE_BPSK, RATE_BPSK};
    end else begin
      for (int x = 0; x < 2; x++) begin
        if (sym_done && wsel == 1'(x)) begin
          full_q[x] <= 1'b1;
          tag_q[x]  <= cur_rate;
        end else if (rd_done && rsel == 1'(x)) begin
          full_q[x] <= 1'b0;
        end
      end
    end
  end

  ilv_rd_ctrl #(.NSC(NSC), .BPSC(BPSC), .MAXB(MAXB), .POS_W(POS_W), .SC_W(SC_W)) u_rd (
    .clk(clk), .rst(rst), .src_full(full_q[rsel]), .src_bits(sym_buf[rsel]),
    .src_rate(tag_q[rsel]), .out_ready(out_ready), .rsel(rsel), .rd_done(rd_done),
    .out_valid(out_valid), .out_bits(out_bits), .out_sc(out_sc), .out_rate(rd_rate)
  );

  // R5: output only starts from a filled buffer
  a_r5_no_early: assert property (@(posedge clk) disable iff (rst)
    $rose(out_valid) |-> $past(full_q != 2'b00));

  // R7: a word is never taken while both buffers are occupied
  a_r7_no_overwrite: assert property (@(posedge clk) disable iff (rst)
    (full_q == 2'b11) |=> $stable(wcnt) && $stable(wsel));
endmodule

// File: tb/ofdm_bit_interleaver_tb.sv
module ofdm_bit_interleaver_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic        in_valid = 1'b0, in_ready;
  logic [15:0] in_data  = '0;
  logic [1:0]  in_rate  = '0;
  logic        out_valid, out_ready = 1'b0;
  logic [5:0]  out_bits, out_sc;
  logic [1:0]  out_rate;

  ofdm_bit_interleaver u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_rate(in_rate), .out_valid(out_valid),
    .out_ready(out_ready), .out_bits(out_bits), .out_sc(out_sc), .out_rate(out_rate)
  );

  int tests = 0, fails = 0;
  int cyc = 0;
  logic [5:0]  exp_bits [2048];
  logic [5:0]  exp_sc   [2048];
  logic [1:0]  exp_rate [2048];
  int          exp_n = 0, cmp_n = 0;
  logic [5:0]  cap_bits [2048];
  logic [5:0]  cap_sc   [2048];
  logic [1:0]  cap_rate [2048];
  int          cap_cyc  [2048];
  int          cap_n = 0;
  logic [15:0] wbuf [18];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (!rst && out_valid && out_ready) begin
      cap_bits[cap_n] = out_bits;
      cap_sc[cap_n]   = out_sc;
      cap_rate[cap_n] = out_rate;
      cap_cyc[cap_n]  = cyc;
      cap_n = cap_n + 1;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  function automatic int bp_of(input int r);
    return (r == 0) ? 1 : (r == 1) ? 2 : (r == 2) ? 4 : 6;
  endfunction

  task automatic make_words();
    for (int i = 0; i < 18; i++) wbuf[i] = 16'($urandom);
  endtask

  // expected stream from the R2/R3/R4 formulas
  task automatic model(input int r);
    int bp, n, s, i, j, c;
    logic y [288];
    logic [5:0] e;
    bp = bp_of(r);
    n  = 48 * bp;
    s  = (bp / 2 < 1) ? 1 : bp / 2;
    for (int k = 0; k < n; k++) begin
      i = (n / 16) * (k % 16) + k / 16;
      j = s * (i / s) + (i + n - (16 * i) / n) % s;
      y[j] = wbuf[k / 16][k % 16];
    end
    for (int q = 0; q < 48; q++) begin
      c = (q + 24) % 48;
      e = '0;
      for (int t = 0; t < bp; t++) e[t] = y[c * bp + t];
      exp_bits[exp_n] = e;
      exp_sc[exp_n]   = 6'(c);
      exp_rate[exp_n] = 2'(r);
      exp_n++;
    end
  endtask

  // called at a falling edge, returns at the falling edge after acceptance
  task automatic put_word(input logic [15:0] d, input int r);
    in_valid = 1'b1;
    in_data  = d;
    in_rate  = 2'(r);
    while (!in_ready) @(negedge clk);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic send_symbol(input int r, input int alt);
    int nw;
    nw = 3 * bp_of(r);
    for (int w = 0; w < nw; w++) put_word(wbuf[w], (w > 0 && alt >= 0) ? alt : r);
  endtask

  task automatic drain_check(input string req);
    while (cap_n < exp_n) @(negedge clk);
    for (int x = cmp_n; x < exp_n; x++) begin
      check(cap_bits[x] == exp_bits[x], req, "subcarrier bits", cap_bits[x], exp_bits[x]);
      check(cap_sc[x] == exp_sc[x], req, "subcarrier index", cap_sc[x], exp_sc[x]);
      check(cap_rate[x] == exp_rate[x], req, "rate tag", cap_rate[x], exp_rate[x]);
    end
    cmp_n = exp_n;
  endtask

  task automatic t_reset();
    check(in_ready == 1'b1, "R1", "in_ready after reset", in_ready, 1);
    check(out_valid == 1'b0, "R1", "out_valid after reset", out_valid, 0);
  endtask

  task automatic t_all_rates();
    out_ready = 1'b1;
    for (int r = 0; r < 4; r++) begin
      make_words();
      model(r);
      send_symbol(r, -1);
      drain_check("R2 R3 R4");
    end
  endtask

  task automatic t_start_timing();
    out_ready = 1'b1;
    make_words();
    model(1);
    for (int w = 0; w < 5; w++) put_word(wbuf[w], 1);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R5", "valid before last word", out_valid, 0);
    put_word(wbuf[5], 1);
    check(out_valid == 1'b0, "R5", "valid right after last word edge", out_valid, 0);
    @(negedge clk);
    check(out_valid == 1'b1, "R5", "valid one cycle later", out_valid, 1);
    drain_check("R5");
  endtask

  task automatic t_rate_latch();
    out_ready = 1'b1;
    make_words();
    model(3);
    send_symbol(3, 0);
    drain_check("R6");
  endtask

  task automatic t_pingpong();
    logic [5:0] hb, hs;
    out_ready = 1'b0;
    make_words(); model(0); send_symbol(0, -1);
    make_words(); model(2); send_symbol(2, -1);
    check(in_ready == 1'b0, "R7", "in_ready with both buffers full", in_ready, 0);
    check(out_valid == 1'b1, "R5", "first symbol offered", out_valid, 1);
    check(out_sc == 6'd24, "R4", "first subcarrier index", out_sc, 24);
    hb = out_bits; hs = out_sc;
    in_valid = 1'b1; in_data = 16'hFFFF; in_rate = 2'd3;
    for (int c = 0; c < 6; c++) begin
      @(negedge clk);
      check(in_ready == 1'b0, "R7", "word refused while full", in_ready, 0);
    end
    in_valid = 1'b0;
    check(out_bits == hb, "R9", "bits held in stall", out_bits, hb);
    check(out_sc == hs, "R9", "index held in stall", out_sc, hs);
    out_ready = 1'b1;
    make_words(); model(3); send_symbol(3, -1);
    drain_check("R7 R8");
  endtask

  task automatic t_random_stall();
    logic [5:0] pb, ps;
    bit was_stall;
    out_ready = 1'b1;
    make_words(); model(2);
    out_ready = 1'b0;
    send_symbol(2, -1);
    was_stall = 1'b0;
    while (cap_n < exp_n) begin
      if (was_stall) begin
        check(out_valid == 1'b1 && out_bits == pb && out_sc == ps, "R9",
              "stalled output stable", out_sc, ps);
      end
      was_stall = out_valid && !out_ready;
      pb = out_bits; ps = out_sc;
      @(negedge clk);
      out_ready = 1'($urandom);
      if (out_ready) was_stall = 1'b0;
    end
    out_ready = 1'b1;
    drain_check("R9");
  endtask

  task automatic t_back_to_back();
    int first;
    out_ready = 1'b1;
    first = exp_n;
    make_words(); model(3); send_symbol(3, -1);
    make_words(); model(1); send_symbol(1, -1);
    drain_check("R10");
    check(cap_cyc[first + 95] - cap_cyc[first] == 95, "R10", "cycles for 96 subcarriers",
          cap_cyc[first + 95] - cap_cyc[first], 95);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_all_rates();
    t_start_timing();
    t_rate_latch();
    t_pingpong();
    t_random_stall();
    t_back_to_back();
    repeat (5) @(negedge clk);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule